// File: doc/BRIEF.md
# Context Fault Recorder and Stall-Resume Controller

This block keeps the fault state of one translation context. Whenever the translation pipeline reports a fault, it sends a one-cycle event that carries a fault kind and the input address of the access. The block records the kind as a sticky flag in a status word. It flags a repeat of a kind that is still recorded, and it latches the address of the first fault. While any flag is set and the enable is on, it drives a level interrupt.

Each fault is handled in one of two ways, chosen by a configuration input:

- **Terminate:** the faulting transaction is ended at once.
- **Stall:** the transaction is held until software acts.

Software uses a small register port. It reads the status, reads the latched address as two 32-bit words, and clears flags by writing ones. It releases a held transaction by writing the resume register, where bit 0 picks retry or terminate. The block then gives the upstream logic a one-cycle retry or terminate pulse. A terminate pulse comes with an abort qualifier when aborts are enabled.

Top module: `cfault_ctrl`

## Requirements
- R1: A fault event of kind k (0 translation, 1 access flag, 2 permission, 3 external, 4 TLB match conflict, 5 TLB lock, 6 address size, 7 unsupported transaction) sets status bit k+1. Status is read at `reg_sel` 0. Bit 0 and bits 29:9 read as zero.
- R2: A write to `reg_sel` 0 clears every flag bit (8:1 and 31) written as 1 and keeps bits written as 0. Bit 30 is not changed by such a write.
- R3: The multi flag (status bit 31) is set when a fault arrives whose kind flag is already set and is not being cleared in the same cycle. A fault of a kind not yet recorded leaves the multi flag alone.
- R4: The fault address is captured only when no flag in bits 8:1 is set. The address reads at `reg_sel` 1 (bits 31:0) and at `reg_sel` 2 (upper bits, zero-extended).
- R5: `irq` is high exactly when a flag in bits 8:1 is set and `cfg_irq_en` was high. It is updated by the same edge that updates the flags.
- R6: A fault is terminated when `cfg_stall` is 0, or when a transaction is already stalled. In that case `xact_term` pulses for one cycle after the event edge, and `xact_abort` equals `cfg_abort_en` during that pulse.
- R7: A fault with `cfg_stall`=1 and nothing stalled sets the stalled state (`xact_stalled`, status bit 30). The state holds until an accepted resume write.
- R8: A resume write (`reg_sel` 3) while stalled clears the stalled state. If bit 0 is 0 it gives a one-cycle `xact_retry` pulse; if bit 0 is 1 it gives a one-cycle `xact_term` pulse with `xact_abort` set to `cfg_abort_en`. The pulse starts at the edge that accepts the write.
- R9: A resume write while not stalled has no effect: no pulse and no state change.
- R10: After reset the status word, the address, `irq`, `xact_stalled` and all pulses are zero.
- R11: `reg_rdata` shows the selected register from the edge that samples `reg_rd` until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_valid | input | 1 | Fault event strobe |
| flt_kind | input | 3 | Fault kind code |
| flt_addr | input | ADDR_W | Input address of the faulting access |
| cfg_stall | input | 1 | 1 stalls faulting transactions, 0 terminates them |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_abort_en | input | 1 | Abort qualifier enable for terminations |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 2 | Register select: 0 status, 1 address low, 2 address high, 3 resume |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level fault interrupt |
| xact_stalled | output | 1 | A faulting transaction is being held |
| xact_retry | output | 1 | One-cycle pulse: retry the held transaction |
| xact_term | output | 1 | One-cycle pulse: terminate the transaction |
| xact_abort | output | 1 | Qualifies `xact_term` with an abort response |

## Verification
Flags, the multi bit, the latched address, `irq`, the stalled state and the retry, terminate and abort pulses all come from one register stage. Each is due in the cycle right after the clock edge that samples the fault event, the register write or the enable change. Read data is due in the cycle after the edge that samples `reg_rd`. The bench drives every stimulus on the falling edge and samples one time unit after the next rising edge, so each check lands in the single cycle a pulse is valid. It checks one cycle later again to confirm a pulse has dropped or a held state has stayed.

// File: rtl/cfault_pkg.sv
package cfault_pkg;
  localparam int KIND_W    = 3;
  localparam int NUM_KINDS = 1 << KIND_W;
  localparam int REG_W     = 32;
  localparam int FLAG_LSB  = 1;
  localparam int STALL_BIT = 30;
  localparam int MULTI_BIT = 31;
  localparam int RESUME_TERM_BIT = 0;

  typedef enum logic [1:0] {
    SEL_STATUS  = 2'd0,
    SEL_ADDR_LO = 2'd1,
    SEL_ADDR_HI = 2'd2,
    SEL_RESUME  = 2'd3
  } reg_sel_e;

  typedef enum logic [KIND_W-1:0] {
    FK_XLATE   = 3'd0,
    FK_ACCFLAG = 3'd1,
    FK_PERM    = 3'd2,
    FK_EXT     = 3'd3,
    FK_TLBCONF = 3'd4,
    FK_TLBLOCK = 3'd5,
    FK_ADDRSZ  = 3'd6,
    FK_UNSUP   = 3'd7
  } fault_kind_e;
endpackage

// File: rtl/cf_flag_bank.sv
module cf_flag_bank
  import cfault_pkg::*;
#(
  parameter int N_KINDS = NUM_KINDS,
  localparam int KW = $clog2(N_KINDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ev_valid,
  input  logic [KW-1:0]      ev_kind,
  input  logic               clr_en,
  input  logic [N_KINDS-1:0] clr_flags,
  input  logic               clr_multi,
  input  logic               irq_en,
  output logic [N_KINDS-1:0] flags_q,
  output logic               multi_q,
  output logic               irq_q
);
  logic [N_KINDS-1:0] ev_hot;
  logic [N_KINDS-1:0] kept;
  logic [N_KINDS-1:0] flags_nxt;
  logic               repeat_hit;
  logic               multi_nxt;

  for (genvar i = 0; i < N_KINDS; i++) begin : g_hot
    assign ev_hot[i] = ev_valid && (ev_kind == KW'(i));
  end

  always_comb begin
    kept       = flags_q & ~(clr_en ? clr_flags : '0);
    flags_nxt  = kept | ev_hot;
    repeat_hit = |(ev_hot & kept);
    multi_nxt  = (multi_q & ~(clr_en & clr_multi)) | repeat_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      multi_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_nxt;
      multi_q <= multi_nxt;
      irq_q   <= irq_en && (|flags_nxt);
    end
  end
endmodule

// File: rtl/cf_addr_hold.sv
module cf_addr_hold #(
  parameter int ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic [ADDR_W-1:0] cap_addr,
  output logic [ADDR_W-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (rst)         addr_q <= '0;
    else if (cap_en) addr_q <= cap_addr;
  end
endmodule

// File: rtl/cf_stall_seq.sv
module cf_stall_seq (
  input  logic clk,
  input  logic rst,
  input  logic ev_valid,
  input  logic cfg_stall,
  input  logic cfg_abort_en,
  input  logic resume_wr,
  input  logic resume_term,
  output logic stalled_q,
  output logic retry_q,
  output logic term_q,
  output logic abort_q
);
  logic stall_set;
  logic fault_term;
  logic resume_ok;
  logic term_nxt;

  always_comb begin
    stall_set  = ev_valid && cfg_stall && !stalled_q;
    fault_term = ev_valid && !stall_set;
    resume_ok  = resume_wr && stalled_q;
    term_nxt   = fault_term || (resume_ok && resume_term);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stalled_q <= 1'b0;
      retry_q   <= 1'b0;
      term_q    <= 1'b0;
      abort_q   <= 1'b0;
    end else begin
      stalled_q <= stall_set || (stalled_q && !resume_ok);
      retry_q   <= resume_ok && !resume_term;
      term_q    <= term_nxt;
      abort_q   <= term_nxt && cfg_abort_en;
    end
  end
endmodule

// File: rtl/cfault_ctrl.sv
module cfault_ctrl
  import cfault_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flt_valid,
  input  logic [KIND_W-1:0] flt_kind,
  input  logic [ADDR_W-1:0] flt_addr,
  input  logic              cfg_stall,
  input  logic              cfg_irq_en,
  input  logic              cfg_abort_en,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq,
  output logic              xact_stalled,
  output logic              xact_retry,
  output logic              xact_term,
  output logic              xact_abort
);
  logic [NUM_KINDS-1:0] flag_vec;
  logic                 multi_bit;
  logic [ADDR_W-1:0]    fault_addr;
  logic                 wr_status;
  logic                 wr_resume;
  logic [REG_W-1:0]     status_word;
  logic [63:0]          addr_wide;
  logic [REG_W-1:0]     rd_mux;

  assign wr_status = reg_wr && (reg_sel == SEL_STATUS);
  assign wr_resume = reg_wr && (reg_sel == SEL_RESUME);

  cf_flag_bank #(.N_KINDS(NUM_KINDS)) i_flags (
    .clk       (clk),
    .rst       (rst),
    .ev_valid  (flt_valid),
    .ev_kind   (flt_kind),
    .clr_en    (wr_status),
    .clr_flags (reg_wdata[FLAG_LSB +: NUM_KINDS]),
    .clr_multi (reg_wdata[MULTI_BIT]),
    .irq_en    (cfg_irq_en),
    .flags_q   (flag_vec),
    .multi_q   (multi_bit),
    .irq_q     (irq)
  );

  cf_addr_hold #(.ADDR_W(ADDR_W)) i_addr (
    .clk      (clk),
    .rst      (rst),
    .cap_en   (flt_valid && (flag_vec == '0)),
    .cap_addr (flt_addr),
    .addr_q   (fault_addr)
  );

  cf_stall_seq i_stall (
    .clk          (clk),
    .rst          (rst),
    .ev_valid     (flt_valid),
    .cfg_stall    (cfg_stall),
    .cfg_abort_en (cfg_abort_en),
    .resume_wr    (wr_resume),
    .resume_term  (reg_wdata[RESUME_TERM_BIT]),
    .stalled_q    (xact_stalled),
    .retry_q      (xact_retry),
    .term_q       (xact_term),
    .abort_q      (xact_abort)
  );

  always_comb begin
    status_word = '0;
    status_word[MULTI_BIT] = multi_bit;
    status_word[STALL_BIT] = xact_stalled;
    status_word[FLAG_LSB +: NUM_KINDS] = flag_vec;
    addr_wide = 64'(fault_addr);
    case (reg_sel)
      SEL_STATUS:  rd_mux = status_word;
      SEL_ADDR_LO: rd_mux = addr_wide[31:0];
      SEL_ADDR_HI: rd_mux = addr_wide[63:32];
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/cfault_ctrl_chk.sv
module cfault_ctrl_chk #(
  parameter int ADDR_W = 48
) (
  input logic              clk,
  input logic              rst,
  input logic              flt_valid,
  input logic              cfg_irq_en,
  input logic              reg_wr,
  input logic [1:0]        reg_sel,
  input logic              irq,
  input logic              xact_stalled,
  input logic              xact_retry,
  input logic              xact_term,
  input logic              xact_abort,
  input logic [7:0]        flag_vec,
  input logic              multi_bit,
  input logic [ADDR_W-1:0] fault_addr
);
  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (flag_vec == '0 && !multi_bit && !xact_stalled && !irq && !xact_retry && !xact_term));

  p_multi_cause_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(multi_bit) |-> $past(flt_valid));

  p_addr_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (flag_vec != '0) |=> $stable(fault_addr));

  p_irq_gate_r5: assert property (@(posedge clk) disable iff (rst)
    !cfg_irq_en |=> !irq);

  p_abort_qual_r6: assert property (@(posedge clk) disable iff (rst)
    xact_abort |-> xact_term);

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (xact_stalled && !(reg_wr && reg_sel == 2'd3)) |=> xact_stalled);

  p_retry_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    xact_retry |=> !xact_retry);

  p_idle_resume_r9: assert property (@(posedge clk) disable iff (rst)
    (!xact_stalled && !flt_valid && reg_wr && reg_sel == 2'd3) |=> (!xact_retry && !xact_term && !xact_stalled));
endmodule

bind cfault_ctrl cfault_ctrl_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk          (clk),
  .rst          (rst),
  .flt_valid    (flt_valid),
  .cfg_irq_en   (cfg_irq_en),
  .reg_wr       (reg_wr),
  .reg_sel      (reg_sel),
  .irq          (irq),
  .xact_stalled (xact_stalled),
  .xact_retry   (xact_retry),
  .xact_term    (xact_term),
  .xact_abort   (xact_abort),
  .flag_vec     (flag_vec),
  .multi_bit    (multi_bit),
  .fault_addr   (fault_addr)
);

// File: tb/test_cfault_ctrl.sv
module test_cfault_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 48;
  localparam int NV = 8;
  // vector: {kind[2:0], clear mask written first[31:0], expected status[31:0]}
  localparam logic [66:0] VEC [NV] = '{
    {3'd0, 32'h0000_0000, 32'h0000_0002},
    {3'd2, 32'h0000_0000, 32'h0000_000A},
    {3'd0, 32'h0000_0000, 32'h8000_000A},
    {3'd7, 32'h8000_0002, 32'h0000_0108},
    {3'd6, 32'h0000_0108, 32'h0000_0080},
    {3'd6, 32'h0000_0080, 32'h0000_0080},
    {3'd6, 32'h0000_0000, 32'h8000_0080},
    {3'd3, 32'hFFFF_FFFF, 32'h0000_0010}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flt_valid = 1'b0;
  logic [2:0] flt_kind = '0;
  logic [AW-1:0] flt_addr = '0;
  logic cfg_stall = 1'b0, cfg_irq_en = 1'b1, cfg_abort_en = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq, xact_stalled, xact_retry, xact_term, xact_abort;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfault_ctrl #(.ADDR_W(AW)) i_cfault_ctrl (
    .clk(clk), .rst(rst), .flt_valid(flt_valid), .flt_kind(flt_kind), .flt_addr(flt_addr),
    .cfg_stall(cfg_stall), .cfg_irq_en(cfg_irq_en), .cfg_abort_en(cfg_abort_en),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .xact_stalled(xact_stalled),
    .xact_retry(xact_retry), .xact_term(xact_term), .xact_abort(xact_abort)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_fault(input logic [2:0] kind, input logic [AW-1:0] addr);
    @(negedge clk);
    flt_valid = 1'b1; flt_kind = kind; flt_addr = addr;
    @(posedge clk); #1;
    flt_valid = 1'b0;
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] sel, output logic [31:0] data);
    @(negedge clk);
    reg_rd = 1'b1; reg_sel = sel;
    @(posedge clk); #1;
    reg_rd = 1'b0;
    data = reg_rdata;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    // R10 reset state
    check("R10 irq", 64'(irq), 64'd0);
    check("R10 stalled", 64'(xact_stalled), 64'd0);
    check("R10 pulses", 64'({xact_retry, xact_term, xact_abort}), 64'd0);
    reg_read(2'd0, d); check("R10 R11 status read", 64'(d), 64'd0);
    reg_read(2'd1, d); check("R10 R11 address read", 64'(d), 64'd0);

    // table walk: terminate mode, R1 R2 R3 R6
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][63:32] != 32'd0) reg_write(2'd0, VEC[i][63:32]);
      do_fault(VEC[i][66:64], AW'(48'h1000 + i));
      check("R6 term pulse", 64'({xact_term, xact_abort, xact_stalled}), 64'b110);
      reg_read(2'd0, d);
      check("R1 R2 R3 status vector", 64'(d), 64'(VEC[i][31:0]));
    end
    @(posedge clk); #1;
    check("R6 term pulse drops", 64'(xact_term), 64'd0);

    // R4 address capture on first fault only
    reg_write(2'd0, 32'hFFFF_FFFF);
    do_fault(3'd1, 48'hABCD_1234_5678);
    do_fault(3'd2, 48'h0000_9999_0000);
    reg_read(2'd1, d); check("R4 address low", 64'(d), 64'h1234_5678);
    reg_read(2'd2, d); check("R4 address high", 64'(d), 64'h0000_ABCD);
    reg_read(2'd0, d); check("R1 two kinds", 64'(d), 64'h0000_000C);

    // R5 interrupt level
    check("R5 irq on", 64'(irq), 64'd1);
    @(negedge clk); cfg_irq_en = 1'b0;
    @(posedge clk); #1; check("R5 irq masked", 64'(irq), 64'd0);
    @(negedge clk); cfg_irq_en = 1'b1;
    @(posedge clk); #1; check("R5 irq unmasked", 64'(irq), 64'd1);
    reg_write(2'd0, 32'h0000_01FE);
    check("R5 irq after clear", 64'(irq), 64'd0);

    // R7 R8 stall then retry
    cfg_stall = 1'b1;
    do_fault(3'd0, 48'h0000_0000_4444);
    check("R7 stalled set", 64'({xact_stalled, xact_term}), 64'b10);
    repeat (3) @(posedge clk); #1;
    check("R7 stalled held", 64'(xact_stalled), 64'd1);
    reg_read(2'd0, d); check("R7 status bit30", 64'(d), 64'h4000_0002);
    reg_write(2'd0, 32'h4000_0002);
    reg_read(2'd0, d); check("R2 bit30 not cleared by status write", 64'(d), 64'h4000_0000);
    do_fault(3'd5, 48'h0);
    check("R6 fault while stalled terminates", 64'({xact_term, xact_stalled}), 64'b11);
    reg_write(2'd3, 32'd0);
    check("R8 retry pulse", 64'({xact_retry, xact_term, xact_stalled}), 64'b100);
    @(posedge clk); #1;
    check("R8 retry one cycle", 64'(xact_retry), 64'd0);

    // R8 stall then terminate, abort disabled
    cfg_abort_en = 1'b0;
    do_fault(3'd4, 48'h0);
    check("R7 stalled again", 64'(xact_stalled), 64'd1);
    reg_write(2'd3, 32'd1);
    check("R8 terminate pulse", 64'({xact_retry, xact_term, xact_abort, xact_stalled}), 64'b0100);

    // R9 resume while idle
    reg_write(2'd3, 32'd0);
    check("R9 idle resume retry", 64'({xact_retry, xact_term, xact_stalled}), 64'b000);
    reg_write(2'd3, 32'd1);
    check("R9 idle resume terminate", 64'({xact_retry, xact_term, xact_stalled}), 64'b000);

    // R6 terminate without abort
    cfg_stall = 1'b0;
    do_fault(3'd7, 48'h0);
    check("R6 abort disabled", 64'({xact_term, xact_abort}), 64'b10);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule